// File: doc/BRIEF.md
# SDRAM Line Drain Controller

This block empties stored video lines out of the SDRAM that the write side is not using at the moment and pushes every word into a dual-clock FIFO, which feeds a slower or faster consumer. It opens one row at a time in a single fixed bank and reads the row as a full-page burst. One row holds one line. The block watches the write-side fill count of the FIFO and starts a new line only when the FIFO can take the whole line. As a result the FIFO stays as full as its size allows. When the FIFO has no room, the controller waits. This delays the moment when it reports the line set as finished, so buffer swaps become less frequent.

The swap logic hands the block a line count together with a one-cycle start pulse. The block then reads rows 0 up to count−1 in ascending order. When the last row has been read, its data has been pushed and the row has been precharged, the block raises a done flag. The flag stays high until the next accepted start. The FIFO and the consumer lie outside this block. The FIFO data input is wired straight from the SDRAM data bus, and the write request is timed to the CAS latency.

Top module: `sdram_fifo_reader`

## Requirements
- R1: During and after reset, before any start, the command pins hold NOP ({cs_n,ras_n,cas_n,we_n} = 0111), the FIFO write request is low and done is low.
- R2: An accepted start with count N causes exactly N ACTIVE commands (0111 → 0011 encoding, i.e. {0,0,1,1}). Their row addresses on sd_addr are 0, 1, …, N−1 in that order. No command other than NOP, ACTIVE, READ (0101) or PRECHARGE (0010) ever appears.
- R3: Each READ follows its ACTIVE by exactly T_RCD cycles and carries column address 0.
- R4: PRECHARGE follows its READ by exactly PAGE cycles and has sd_addr bit 10 low, so only the selected bank closes.
- R5: The FIFO write request is high in exactly the cycles READ+CAS_LAT through READ+CAS_LAT+PAGE−1, giving PAGE words per line. fifo_data_o equals sd_dq_i in those cycles.
- R6: An ACTIVE is issued only if, in the cycle before it, DEPTH − fifo_used_i ≥ PAGE. Otherwise the controller waits and the FIFO is never overfilled.
- R7: Each ACTIVE comes at least T_RP cycles after the preceding PRECHARGE.
- R8: Done rises only after every line's words have been pushed and its precharge has completed. It then stays high with NOP and no write request. A count of zero gives done with no command at all.
- R9: A start pulse arriving while a line set is in progress is ignored. The count in progress and the number of rows read do not change.
- R10: An accepted start clears done in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that hands over a line set |
| lines_i | input | ROW_W+1 | Number of lines in the set, sampled with start_i |
| fifo_used_i | input | FIFO_AW+1 | FIFO write-side used-word count |
| sd_dq_i | input | DATA_W | SDRAM read data |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W | SDRAM bank select, tied to BANK |
| sd_addr | output | ADDR_W | SDRAM row/column address |
| fifo_wrreq_o | output | 1 | FIFO write request |
| fifo_data_o | output | DATA_W | FIFO write data |
| done_o | output | 1 | All lines of the set read |

## Verification
Two functions share cycles. The first is the closing PRECHARGE of a line. The second is the tail of that line's FIFO pushes, which goes on for CAS_LAT cycles after the precharge. A third case is the room check for the next line: it must not act on a fill count that has not yet seen those tail words. The bench provokes this with runs where the consumer drains quickly, so a new line becomes legal as soon as timing permits. It also runs cases with no drain, where the FIFO reaches exactly DEPTH and the next line must stall. Each push is checked against the window counted from its READ and against a pixel value computed from the row and column. Each ACTIVE is checked against the fill count seen in the cycle before it, and the FIFO model must never exceed DEPTH.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACT,
    ST_RCD,
    ST_READ,
    ST_BURST,
    ST_PRE,
    ST_RP
  } srd_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } srd_cmd_t;

  localparam srd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam srd_cmd_t CMD_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam srd_cmd_t CMD_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam srd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

  // True when a whole line still fits into the FIFO.
  function automatic logic fifo_has_room(input int used, input int depth, input int page);
    return (used <= depth) && ((depth - used) >= page);
  endfunction

  // Cycles spent after PRECHARGE: enough for tRP and for the data tail to drain.
  function automatic int post_cycles(input int t_rp, input int cas_lat);
    return ((t_rp - 1) > cas_lat) ? (t_rp - 1) : cas_lat;
  endfunction

endpackage

// File: rtl/srd_seq.sv
module srd_seq
  import srd_pkg::*;
#(
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int CAS_LAT = 2,
  parameter int PAGE    = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_go,
  input  logic       room_ok,
  input  logic       rows_remain,
  output srd_state_e state_o,
  output logic       row_adv_o,
  output logic       set_done_o,
  output logic       burst_live_o
);

  localparam int POST  = post_cycles(T_RP, CAS_LAT);
  localparam int TMR_W = $clog2(PAGE + POST + T_RCD + 1);

  srd_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d       = st_q;
    tmr_d      = tmr_q;
    row_adv_o  = 1'b0;
    set_done_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_go) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!rows_remain) begin
          st_d       = ST_IDLE;
          set_done_o = 1'b1;
        end else if (room_ok) begin
          st_d = ST_ACT;
        end
      end
      ST_ACT: begin
        st_d  = ST_RCD;
        tmr_d = TMR_W'(T_RCD - 2);
      end
      ST_RCD: begin
        if (tmr_zero) st_d = ST_READ;
        else          tmr_d = tmr_q - 1'b1;
      end
      ST_READ: begin
        st_d  = ST_BURST;
        tmr_d = TMR_W'(PAGE - 2);
      end
      ST_BURST: begin
        if (tmr_zero) st_d = ST_PRE;
        else          tmr_d = tmr_q - 1'b1;
      end
      ST_PRE: begin
        st_d  = ST_RP;
        tmr_d = TMR_W'(POST - 1);
      end
      ST_RP: begin
        if (tmr_zero) begin
          st_d      = ST_WAIT;
          row_adv_o = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign state_o      = st_q;
  assign burst_live_o = (st_q == ST_READ) || (st_q == ST_BURST);

  AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_go) |=> (st_q == ST_IDLE)) // R9
    else $error("sequencer left idle without a start");

endmodule

// File: rtl/srd_rows.sv
module srd_rows #(
  parameter int ROW_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_go,
  input  logic [ROW_W:0] lines_i,
  input  logic           row_adv,
  input  logic           set_done,
  output logic [ROW_W:0] row_o,
  output logic [ROW_W:0] lines_o,
  output logic           rows_remain_o,
  output logic           done_o
);

  logic [ROW_W:0] row_q, lines_q;
  logic           done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      lines_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (start_go) begin
        row_q   <= '0;
        lines_q <= lines_i;
        done_q  <= 1'b0;
      end else begin
        if (row_adv)  row_q  <= row_q + 1'b1;
        if (set_done) done_q <= 1'b1;
      end
    end
  end

  assign row_o         = row_q;
  assign lines_o       = lines_q;
  assign rows_remain_o = (row_q < lines_q);
  assign done_o        = done_q;

  AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= lines_q) // R2
    else $error("row pointer passed the line count");

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !done_q) // R10
    else $error("done survived an accepted start");

endmodule

// File: rtl/srd_retpipe.sv
module srd_retpipe #(
  parameter int CAS_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_live,
  output logic push_o
);

  logic [CAS_LAT-1:0] sh_q;

  generate
    if (CAS_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= burst_live;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[CAS_LAT-2:0], burst_live};
      end
    end
  endgenerate

  assign push_o = sh_q[CAS_LAT-1];

endmodule

// File: rtl/sdram_fifo_reader.sv
module sdram_fifo_reader
  import srd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 10,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int BANK    = 0,
  parameter int FIFO_AW = 12,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W:0]    lines_i,
  input  logic [FIFO_AW:0]  fifo_used_i,
  input  logic [DATA_W-1:0] sd_dq_i,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              fifo_wrreq_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              done_o
);

  localparam int PAGE  = 1 << COL_W;
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int PCW   = COL_W + 2;

  srd_state_e     state;
  srd_cmd_t       cmd;
  logic           start_go, room_ok, rows_remain, row_adv, set_done, burst_live;
  logic [ROW_W:0] row_q, lines_q;

  // named events for the checks
  logic ev_act, ev_read, ev_pre, ev_push, ev_idle;

  assign ev_idle  = (state == ST_IDLE);
  assign start_go = start_i && ev_idle;
  assign room_ok  = fifo_has_room(int'(fifo_used_i), DEPTH, PAGE);

  srd_seq #(
    .T_RCD(T_RCD), .T_RP(T_RP), .CAS_LAT(CAS_LAT), .PAGE(PAGE)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .room_ok(room_ok),
    .rows_remain(rows_remain), .state_o(state), .row_adv_o(row_adv),
    .set_done_o(set_done), .burst_live_o(burst_live)
  );

  srd_rows #(.ROW_W(ROW_W)) i_rows (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .lines_i(lines_i),
    .row_adv(row_adv), .set_done(set_done), .row_o(row_q),
    .lines_o(lines_q), .rows_remain_o(rows_remain), .done_o(done_o)
  );

  srd_retpipe #(.CAS_LAT(CAS_LAT)) i_ret (
    .clk(clk), .rst_n(rst_n), .burst_live(burst_live), .push_o(ev_push)
  );

  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    case (state)
      ST_ACT:  begin
        cmd     = CMD_ACT;
        sd_addr = {{(ADDR_W-ROW_W){1'b0}}, row_q[ROW_W-1:0]};
      end
      ST_READ: cmd = CMD_RD;
      ST_PRE:  cmd = CMD_PRE;
      default: cmd = CMD_NOP;
    endcase
  end

  assign ev_act  = (state == ST_ACT);
  assign ev_read = (state == ST_READ);
  assign ev_pre  = (state == ST_PRE);

  assign sd_cs_n      = cmd.cs_n;
  assign sd_ras_n     = cmd.ras_n;
  assign sd_cas_n     = cmd.cas_n;
  assign sd_we_n      = cmd.we_n;
  assign sd_ba        = BA_W'(BANK);
  assign fifo_wrreq_o = ev_push;
  assign fifo_data_o  = sd_dq_i;

  // push counter used only by the checks below
  logic [PCW-1:0] push_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      push_cnt_q <= '0;
    else if (ev_act) push_cnt_q <= '0;
    else if (ev_push) push_cnt_q <= push_cnt_q + 1'b1;
  end

  AST_ACT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |-> $past(room_ok)) // R6
    else $error("row opened without room in the FIFO");

  AST_READ_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |-> $past(ev_act, T_RCD)) // R3
    else $error("READ not T_RCD after ACTIVE");

  AST_PRE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |-> ($past(burst_live) && !burst_live)) // R4
    else $error("PRECHARGE outside burst end");

  AST_PUSH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> $past(burst_live, CAS_LAT)) // R5
    else $error("FIFO push outside the data window");

  AST_FULL_LINE_PUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |-> (push_cnt_q == '0 || push_cnt_q == PCW'(PAGE))) // R5
    else $error("previous line pushed a wrong word count");

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd == CMD_NOP && !ev_push)) // R8
    else $error("activity while done");

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ev_idle) |=> $stable(lines_q)) // R9
    else $error("busy start changed the line count");

endmodule

// File: tb/test_sdram_fifo_reader.sv
module test_sdram_fifo_reader;

  localparam int DATA_W  = 16;
  localparam int ROW_W   = 4;
  localparam int COL_W   = 5;
  localparam int ADDR_W  = 13;
  localparam int BA_W    = 2;
  localparam int FIFO_AW = 7;
  localparam int T_RCD   = 2;
  localparam int T_RP    = 3;
  localparam int CL      = 2;
  localparam int PAGE    = 1 << COL_W;
  localparam int DEPTH   = 1 << FIFO_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ROW_W:0]    lines_i = '0;
  logic [FIFO_AW:0]  fifo_used_i = '0;
  logic [DATA_W-1:0] sd_dq_i = '0;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0]   sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic              fifo_wrreq_o, done_o;
  logic [DATA_W-1:0] fifo_data_o;

  sdram_fifo_reader #(
    .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .BA_W(BA_W), .BANK(0), .FIFO_AW(FIFO_AW), .T_RCD(T_RCD),
    .T_RP(T_RP), .CAS_LAT(CL)
  ) i_sdram_fifo_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lines_i(lines_i),
    .fifo_used_i(fifo_used_i), .sd_dq_i(sd_dq_i), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .fifo_wrreq_o(fifo_wrreq_o),
    .fifo_data_o(fifo_data_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pix(input int row, input int col);
    return DATA_W'((row * 131 + col * 7 + 933) ^ (col << 9));
  endfunction

  function automatic bit room_rule(input int used);
    return (DEPTH - used) >= PAGE;
  endfunction

  // model state
  int cyc = 0;
  int used_m = 0;
  int drain_pct = 100;
  int exp_row = 0;
  int cur_row = 0;
  int act_cyc = -1000;
  int rd_cyc = -1000;
  int pre_cyc = -1000;
  bit have_pre = 0;
  int push_idx = 0;
  int pushes_run = 0;

  always @(negedge clk) begin
    logic [3:0] c;
    int nc;
    cyc++;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      if (c == 4'b0011) begin
        check(room_rule(int'(fifo_used_i)), "R6 room at ACTIVE", int'(fifo_used_i), DEPTH - PAGE);
        check(int'(sd_addr) == exp_row, "R2 row order", int'(sd_addr), exp_row);
        if (have_pre) check(cyc - pre_cyc >= T_RP, "R7 precharge gap", cyc - pre_cyc, T_RP);
        act_cyc = cyc; cur_row = exp_row; exp_row++; push_idx = 0;
      end else if (c == 4'b0101) begin
        check(cyc - act_cyc == T_RCD, "R3 ACT to READ", cyc - act_cyc, T_RCD);
        check(sd_addr == '0, "R3 column", int'(sd_addr), 0);
        rd_cyc = cyc;
      end else if (c == 4'b0010) begin
        check(cyc - rd_cyc == PAGE, "R4 READ to PRE", cyc - rd_cyc, PAGE);
        check(sd_addr[10] == 1'b0, "R4 addr bit10", int'(sd_addr[10]), 0);
        pre_cyc = cyc; have_pre = 1;
      end else if (c != 4'b0111) begin
        check(0, "R2 illegal command", int'(c), 7);
      end
      if (fifo_wrreq_o) begin
        check(cyc >= rd_cyc + CL && cyc < rd_cyc + CL + PAGE, "R5 push window", cyc - rd_cyc, CL);
        check(fifo_data_o == pix(cur_row, push_idx), "R5 push data",
              int'(fifo_data_o), int'(pix(cur_row, push_idx)));
        push_idx++; pushes_run++; used_m++;
      end else if (cyc >= rd_cyc + CL && cyc < rd_cyc + CL + PAGE) begin
        check(0, "R5 push missing", 0, 1);
      end
      if (used_m > DEPTH) check(0, "R6 FIFO overfilled", used_m, DEPTH);
      if (used_m > 0 && $urandom_range(99) < drain_pct) used_m--;
      fifo_used_i = (FIFO_AW+1)'(used_m);
      nc = cyc + 1;
      if (nc >= rd_cyc + CL && nc < rd_cyc + CL + PAGE) sd_dq_i = pix(cur_row, nc - rd_cyc - CL);
      else sd_dq_i = DATA_W'(16'hbeef);
    end
  end

  task automatic wait_done(input int limit);
    for (int t = 0; t < limit && !done_o; t++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_run(input int lines, input int drain, input bit poke);
    @(negedge clk); #1;
    drain_pct = drain; exp_row = 0; pushes_run = 0; have_pre = 0;
    lines_i = (ROW_W+1)'(lines); start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    check(done_o == 1'b0, "R10 done cleared by start", int'(done_o), 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      #1;
      lines_i = (ROW_W+1)'(lines + 3); start_i = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0;
      check(done_o == 1'b0, "R9 busy start no effect on done", int'(done_o), 0);
    end
    wait_done(20000);
    check(done_o == 1'b1, "R8 done raised", int'(done_o), 1);
    check(exp_row == lines, "R2 rows per set", exp_row, lines);
    check(pushes_run == lines * PAGE, "R5 words per set", pushes_run, lines * PAGE);
    repeat (4) @(negedge clk);
    #1;
    check(done_o && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !fifo_wrreq_o,
          "R8 done holds quiet", int'(done_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    #1;
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP in reset",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    check(!fifo_wrreq_o && !done_o, "R1 quiet in reset", int'({fifo_wrreq_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !fifo_wrreq_o && !done_o,
          "R1 idle after reset", int'(done_o), 0);

    // zero lines: done with no command
    do_run(0, 100, 0);
    check(exp_row == 0 && pushes_run == 0, "R8 empty set", exp_row, 0);

    // fast drain, back to back lines
    do_run(3, 100, 0);
    // busy start is ignored
    do_run(4, 100, 1);

    // stall on full FIFO
    @(negedge clk); #1;
    drain_pct = 0; exp_row = 0; pushes_run = 0; have_pre = 0;
    lines_i = (ROW_W+1)'(6); start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    repeat (600) @(negedge clk);
    #1;
    check(exp_row == DEPTH / PAGE, "R6 stall at full", exp_row, DEPTH / PAGE);
    check(used_m == DEPTH, "R6 filled to depth", used_m, DEPTH);
    check(!done_o, "R8 no done while stalled", int'(done_o), 0);
    drain_pct = 50;
    wait_done(20000);
    check(done_o && exp_row == 6, "R2 stalled set finishes", exp_row, 6);
    check(pushes_run == 6 * PAGE, "R5 stalled set words", pushes_run, 6 * PAGE);

    // random sets
    for (int k = 0; k < 8; k++) begin
      int ln, dr;
      ln = 1 + $urandom_range(11);
      dr = 20 + $urandom_range(80);
      do_run(ln, dr, bit'(k % 3 == 1));
    end

    // full row range
    do_run(1 << ROW_W, 100, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule